// File: doc/BRIEF.md
# Counted Pipelined Loop Branch Unit

This block decides the outcome of the loop-closing branches used by counted loops and by software-pipelined loops. It keeps two counters of its own: a trip counter holding the remaining iterations minus one, and a drain counter holding the number of pipeline stages still to empty once the trip counter is exhausted. Each time the evaluate strobe is raised with a branch kind, the block updates its counters. One cycle later it reports three things: whether the branch is taken, the bit to be written into the highest rotating predicate, and a strobe that steps the register rotation.

Three branch kinds are supported. The plain counted loop only uses the trip counter and never rotates. The pipelined counted loop injects a 1 into the rotating predicate while iterations remain. It then injects 0 while the pipeline drains, and falls through on the last drain step. The pipelined while loop does the same, but a predicate supplied with the strobe replaces the trip counter. Software loads both counters through dedicated write ports before the loop starts. Fetch and predicate storage sit outside the block.

Top module: `loop_branch_unit`

## Requirements
- R1: After reset both counters are 0, and `taken_o`, `rotate_o` and `pred_o` are 0.
- R2: Kind 2'b00 (plain counted): if the trip counter is nonzero it is decremented and the branch is taken. Otherwise the branch falls through and the counter is unchanged. `rotate_o` and `pred_o` stay 0 in both cases.
- R3: Kinds 2'b01 and 2'b10: every evaluation raises `rotate_o`.
- R4: Kind 2'b01 (pipelined counted) with a nonzero trip counter: the trip counter is decremented, `pred_o` is 1 and the branch is taken. The drain counter is unchanged.
- R5: Kinds 2'b01 and 2'b10, when the trip condition fails and the drain counter is above 1: the drain counter is decremented, `pred_o` is 0 and the branch is taken.
- R6: Kinds 2'b01 and 2'b10, when the trip condition fails and the drain counter is 0 or 1: `pred_o` is 0 and the branch falls through. The drain counter is decremented, saturating at 0.
- R7: Kind 2'b10 (pipelined while) with `loop_pred_i` = 1: `pred_o` is 1, the branch is taken, and neither counter changes. The trip counter is never touched by this kind.
- R8: Results appear in the cycle after the evaluate strobe, last exactly one cycle, and are all 0 in any cycle not preceded by an evaluation.
- R9: A write to either counter in the same cycle as an evaluation cancels that evaluation: no outputs are raised and only the written value(s) take effect.
- R10: Kind 2'b11 is reserved. An evaluation with it raises no output and leaves both counters unchanged.
- R11: With trip 3 and drain 4 loaded, pipelined counted evaluations are taken six times, with predicates 1,1,1,0,0,0. The seventh evaluation falls through, and further evaluations keep falling through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_i | input | 1 | Evaluate a loop branch this cycle |
| kind_i | input | 2 | Branch kind: 00 plain, 01 pipelined counted, 10 pipelined while, 11 reserved |
| loop_pred_i | input | 1 | Continue predicate for the while kind |
| trip_we_i | input | 1 | Write the trip counter |
| trip_wdata_i | input | TRIP_W | Trip counter write value |
| drain_we_i | input | 1 | Write the drain counter |
| drain_wdata_i | input | DRAIN_W | Drain counter write value |
| taken_o | output | 1 | Branch taken |
| rotate_o | output | 1 | Step register rotation |
| pred_o | output | 1 | Value for the highest rotating predicate |

## Verification
The counters cannot be read, so every counter state has to be inferred from later branch outcomes. The cases that are hardest to reach are a counter write colliding with an evaluation and a drain counter already at zero. The bench drives the strobe and a write in the same cycle, checks that nothing is raised, and then counts the evaluations up to fall-through to confirm which value was kept. The saturation case is reached by draining a loop completely and then evaluating again, which must fall through with a 0 predicate and a rotate.

// File: rtl/loop_branch_unit.sv
module loop_branch_unit #(
  parameter int TRIP_W  = 64,
  parameter int DRAIN_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               eval_i,
  input  logic [1:0]         kind_i,
  input  logic               loop_pred_i,
  input  logic               trip_we_i,
  input  logic [TRIP_W-1:0]  trip_wdata_i,
  input  logic               drain_we_i,
  input  logic [DRAIN_W-1:0] drain_wdata_i,
  output logic               taken_o,
  output logic               rotate_o,
  output logic               pred_o
);
  localparam logic [1:0] K_PLAIN = 2'b00;
  localparam logic [1:0] K_PCNT  = 2'b01;
  localparam logic [1:0] K_PWHL  = 2'b10;
  localparam logic [DRAIN_W-1:0] D_ONE = DRAIN_W'(1);

  logic [TRIP_W-1:0]  trip_q, trip_d;
  logic [DRAIN_W-1:0] drain_q, drain_d;
  logic taken_d, rotate_d, pred_d;

  wire wr_any    = trip_we_i | drain_we_i;
  wire do_eval   = eval_i & ~wr_any;
  wire trip_nz   = |trip_q;
  wire drain_gt1 = drain_q > D_ONE;
  wire [DRAIN_W-1:0] drain_dec = (drain_q == '0) ? '0 : drain_q - D_ONE;
  wire pipe_go   = (kind_i == K_PCNT) ? trip_nz : loop_pred_i;

  always_comb begin
    trip_d   = trip_we_i  ? trip_wdata_i  : trip_q;
    drain_d  = drain_we_i ? drain_wdata_i : drain_q;
    taken_d  = 1'b0;
    rotate_d = 1'b0;
    pred_d   = 1'b0;
    if (do_eval) begin
      case (kind_i)
        K_PLAIN: if (trip_nz) begin
          trip_d  = trip_q - 1'b1;
          taken_d = 1'b1;
        end
        K_PCNT, K_PWHL: begin
          rotate_d = 1'b1;
          if (pipe_go) begin
            pred_d  = 1'b1;
            taken_d = 1'b1;
            if (kind_i == K_PCNT) trip_d = trip_q - 1'b1;
          end else begin
            drain_d = drain_dec;
            taken_d = drain_gt1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trip_q   <= '0;
      drain_q  <= '0;
      taken_o  <= 1'b0;
      rotate_o <= 1'b0;
      pred_o   <= 1'b0;
    end else begin
      trip_q   <= trip_d;
      drain_q  <= drain_d;
      taken_o  <= taken_d;
      rotate_o <= rotate_d;
      pred_o   <= pred_d;
    end
  end

  p_plain_no_rotate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && !wr_any && kind_i == K_PLAIN) |=> (!rotate_o && !pred_o));
  p_pipe_rotates_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && !wr_any && kind_i[1] != kind_i[0]) |=> rotate_o);
  p_pred_needs_rotate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pred_o |-> rotate_o);
  p_drain_saturates_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !drain_we_i |=> drain_q <= $past(drain_q));
  p_trip_monotone_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !trip_we_i |=> trip_q <= $past(trip_q));
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_i |=> (!taken_o && !rotate_o && !pred_o));
  p_write_cancels_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_we_i || drain_we_i) |=> (!taken_o && !rotate_o));
  p_while_keeps_trip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && !trip_we_i && kind_i == K_PWHL) |=> $stable(trip_q));
  p_reserved_inert_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && !wr_any && kind_i == 2'b11) |=> ($stable(trip_q) && $stable(drain_q) && !taken_o));
endmodule

// File: tb/loop_branch_unit_test.sv
module loop_branch_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic eval_i = 1'b0;
  logic [1:0] kind_i = 2'b00;
  logic loop_pred_i = 1'b0;
  logic trip_we_i = 1'b0;
  logic [63:0] trip_wdata_i = '0;
  logic drain_we_i = 1'b0;
  logic [5:0] drain_wdata_i = '0;
  logic taken_o, rotate_o, pred_o;
  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  loop_branch_unit uut (
    .clk(clk), .rst_n(rst_n), .eval_i(eval_i), .kind_i(kind_i),
    .loop_pred_i(loop_pred_i), .trip_we_i(trip_we_i), .trip_wdata_i(trip_wdata_i),
    .drain_we_i(drain_we_i), .drain_wdata_i(drain_wdata_i),
    .taken_o(taken_o), .rotate_o(rotate_o), .pred_o(pred_o));

  task automatic chk(input string req, input logic [2:0] exp);
    tests++;
    if ({taken_o, rotate_o, pred_o} !== exp) begin
      fails++;
      $display("FAIL %s: {taken,rotate,pred} got %b expected %b", req, {taken_o, rotate_o, pred_o}, exp);
    end
  endtask

  task automatic ld(input logic wt, input logic [63:0] t, input logic wd, input logic [5:0] d);
    @(negedge clk);
    trip_we_i = wt; trip_wdata_i = t; drain_we_i = wd; drain_wdata_i = d;
    @(negedge clk);
    trip_we_i = 1'b0; drain_we_i = 1'b0;
  endtask

  task automatic ev(input logic [1:0] k, input logic p, input string req, input logic [2:0] exp);
    @(negedge clk);
    eval_i = 1'b1; kind_i = k; loop_pred_i = p;
    @(negedge clk);
    eval_i = 1'b0; loop_pred_i = 1'b0;
    chk(req, exp);
  endtask

  task automatic t_reset;
    chk("R1 outputs after reset", 3'b000);
    ev(2'b00, 1'b0, "R1 trip zero after reset", 3'b000);
    ev(2'b01, 1'b0, "R1/R6 drain zero after reset", 3'b010);
  endtask

  task automatic t_plain;
    ld(1'b1, 64'd2, 1'b0, 6'd0);
    ev(2'b00, 1'b0, "R2 plain taken", 3'b100);
    ev(2'b00, 1'b0, "R2 plain taken", 3'b100);
    ev(2'b00, 1'b0, "R2 plain fall through", 3'b000);
    ev(2'b00, 1'b0, "R2 plain stays at zero", 3'b000);
  endtask

  task automatic t_counted;
    ld(1'b1, 64'd3, 1'b1, 6'd4);
    for (int i = 0; i < 3; i++) ev(2'b01, 1'b0, "R4/R11 kernel", 3'b111);
    for (int i = 0; i < 3; i++) ev(2'b01, 1'b0, "R5/R11 drain", 3'b110);
    ev(2'b01, 1'b0, "R6/R11 last falls through", 3'b010);
    ev(2'b01, 1'b0, "R6/R11 saturated at zero", 3'b010);
  endtask

  task automatic t_while;
    ld(1'b1, 64'd1, 1'b1, 6'd3);
    ev(2'b10, 1'b1, "R7 while continue", 3'b111);
    ev(2'b10, 1'b1, "R7 while continue", 3'b111);
    ev(2'b10, 1'b0, "R5 while drain", 3'b110);
    ev(2'b10, 1'b0, "R5 while drain", 3'b110);
    ev(2'b10, 1'b0, "R6 while exit", 3'b010);
    ev(2'b00, 1'b0, "R7 trip untouched by while", 3'b100);
    ev(2'b00, 1'b0, "R7 trip was exactly one", 3'b000);
  endtask

  task automatic t_collide;
    @(negedge clk);
    eval_i = 1'b1; kind_i = 2'b00; trip_we_i = 1'b1; trip_wdata_i = 64'd2;
    @(negedge clk);
    eval_i = 1'b0; trip_we_i = 1'b0;
    chk("R9 trip write cancels eval", 3'b000);
    ev(2'b00, 1'b0, "R9 written trip used", 3'b100);
    ev(2'b00, 1'b0, "R9 written trip used", 3'b100);
    ev(2'b00, 1'b0, "R9 written trip exhausted", 3'b000);
    @(negedge clk);
    eval_i = 1'b1; kind_i = 2'b01; drain_we_i = 1'b1; drain_wdata_i = 6'd2;
    @(negedge clk);
    eval_i = 1'b0; drain_we_i = 1'b0;
    chk("R9 drain write cancels eval", 3'b000);
    ev(2'b01, 1'b0, "R9 written drain used", 3'b110);
    ev(2'b01, 1'b0, "R9 written drain exhausted", 3'b010);
  endtask

  task automatic t_reserved_idle;
    ld(1'b1, 64'd1, 1'b1, 6'd2);
    ev(2'b11, 1'b1, "R10 reserved kind inert", 3'b000);
    ev(2'b00, 1'b0, "R10 trip kept", 3'b100);
    ev(2'b00, 1'b0, "R10 trip kept exactly", 3'b000);
    ev(2'b01, 1'b0, "R10 drain kept", 3'b110);
    @(negedge clk);
    chk("R8 pulse lasts one cycle", 3'b000);
    @(negedge clk);
    chk("R8 idle quiet", 3'b000);
  endtask

  task automatic t_wide;
    ld(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 6'd63);
    ev(2'b00, 1'b0, "R2 wide trip taken", 3'b100);
    ev(2'b01, 1'b0, "R4 wide trip kernel", 3'b111);
    ld(1'b1, 64'd0, 1'b0, 6'd0);
    ev(2'b01, 1'b0, "R5 wide drain", 3'b110);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain();
    t_counted();
    t_while();
    t_collide();
    t_reserved_idle();
    t_wide();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule